// File: doc/BRIEF.md
# Stream Packet Deframer with Context Split

This block sits on a 64-bit AXI4-Stream carrying framed packets. Every packet opens with a single header word. A timestamp word may follow the header, then a number of metadata words, and then the payload. The block reads the header and uses it to split the packet across two AXI4-Stream outputs. The context output carries the header, the timestamp and the metadata words, and each of them is labelled on `tuser`. The payload output carries the payload words. On the final payload beat, `tkeep` is set per 32-bit item from the byte length in the header.

The header decides the layout. A packet type of 7 means a timestamp word is present, and any other type means there is none. A 5-bit count gives the number of metadata words. A 16-bit byte length covers the whole packet, so subtracting the header, timestamp and metadata bytes from it gives the payload size. If a header breaks the layout rules, its packet is consumed up to the input `tlast` and appears on neither output, and the block raises a one-cycle error pulse. Each output has its own two-entry buffer, so either consumer can stall the input without losing data.

Top module: `pkt_deframer`

## Requirements
- R1: The first word of each well-formed packet appears on the context output unchanged, with `ctx_tuser` = 0.
- R2: When header bits [55:53] equal 7, the second input word appears on the context output with `ctx_tuser` = 2. For any other type no timestamp word exists, and the code 1 never appears on `ctx_tuser`.
- R3: The metadata word count comes from header bits [52:48]. That many words follow the header (or the timestamp) and appear in order on the context output with `ctx_tuser` = 3.
- R4: `ctx_tlast` is 1 on the last context word of a packet and 0 on every other context word.
- R5: All remaining input words up to and including the input `tlast` appear in order on the payload output. `pay_tlast` marks the final one.
- R6: `pay_tkeep` bit i covers 32-bit item i (bits [32i+31:32i]). Every beat other than the last has `pay_tkeep` = 2'b11. On the last beat, `pay_tkeep` is 2'b11 when the payload byte count (header bits [31:16] minus 8 bytes per context word) is a multiple of 8, and 2'b01 when it leaves a remainder of 4.
- R7: A header whose metadata count exceeds 30 causes the whole packet to be dropped through its `tlast`, with no output beats and one `err_pulse` cycle.
- R8: A header whose byte length is less than its context bytes plus 4 causes the packet to be dropped in the same way as R7. The next packet is then processed normally.
- R9: While an output is valid and its `tready` is low, that output's data is held stable. Under arbitrary stalls on both outputs, every beat is delivered exactly once and in order.
- R10: While reset is asserted and on the first cycle after it, both outputs are invalid and `err_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_tdata | input | 64 | Input packet word |
| s_tvalid | input | 1 | Input word valid |
| s_tlast | input | 1 | Last word of input packet |
| s_tready | output | 1 | Input word accepted |
| ctx_tdata | output | 64 | Context word |
| ctx_tuser | output | 2 | Context word kind: 0 header, 2 timestamp, 3 metadata |
| ctx_tlast | output | 1 | Last context word of the packet |
| ctx_tvalid | output | 1 | Context word valid |
| ctx_tready | input | 1 | Context consumer ready |
| pay_tdata | output | 64 | Payload word |
| pay_tkeep | output | 2 | Valid 32-bit items in the payload word |
| pay_tlast | output | 1 | Last payload word |
| pay_tvalid | output | 1 | Payload word valid |
| pay_tready | input | 1 | Payload consumer ready |
| err_pulse | output | 1 | One-cycle flag for a dropped malformed packet |

## Verification
Two things can happen in the same cycle: the header of a malformed packet is rejected while earlier payload words are still held in the stalled payload buffer. The bench sets this up by sending a good packet with both `tready` inputs toggling, then a malformed packet, then a good one. It counts exactly one error pulse. It then checks that the held payload drains intact, that no beat from the dropped packet leaks out, and that the packet after the drop is split correctly.

// File: rtl/pkt_deframer_pkg.sv
// Package: shared encodings for the packet deframer.
// Assumes header fields at fixed bit positions of a 64-bit header word.
package pkt_deframer_pkg;

    // Parser phase of the current input packet
    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_CTX  = 2'd1,
        ST_PAY  = 2'd2,
        ST_DROP = 2'd3
    } parse_st_t;

    // Context word kinds reported on ctx_tuser
    localparam logic [1:0] KIND_HDR  = 2'd0;
    localparam logic [1:0] KIND_TIME = 2'd2;
    localparam logic [1:0] KIND_META = 2'd3;

    // Packet type that carries a timestamp word
    localparam logic [2:0] TYPE_TIMED = 3'd7;

endpackage

// File: rtl/pkt_skid.sv
// Module: two-entry elastic buffer on a valid/ready link.
// Assumes nothing about the payload; in_ready depends only on registered
// occupancy, so no combinational path runs from out_ready to in_ready.
module pkt_skid #(
    parameter int W = 67
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_data,
    input  logic         in_valid,
    output logic         in_ready,
    output logic [W-1:0] out_data,
    output logic         out_valid,
    input  logic         out_ready
);
    logic [W-1:0] head_q, tail_q;
    logic [1:0]   cnt_q;
    logic         push, pop;

    assign in_ready  = (cnt_q != 2'd2);
    assign out_valid = (cnt_q != 2'd0);
    assign out_data  = head_q;
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;

    // Occupancy and entry storage update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= 2'd0;
            head_q <= '0;
            tail_q <= '0;
        end else begin
            case ({push, pop})
                2'b10: begin
                    if (cnt_q == 2'd0) head_q <= in_data;
                    else               tail_q <= in_data;
                    cnt_q <= cnt_q + 2'd1;
                end
                2'b01: begin
                    head_q <= tail_q;
                    cnt_q  <= cnt_q - 2'd1;
                end
                2'b11: begin
                    if (cnt_q == 2'd1) begin
                        head_q <= in_data;
                    end else begin
                        head_q <= tail_q;
                        tail_q <= in_data;
                    end
                end
                default: ;
            endcase
        end
    end

    // R9: a stalled output keeps its word
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/pkt_hdr_parse.sv
// Module: header-driven parser that steers each input word to the context
// or payload stream, labels context words, computes the last-beat keep and
// drops malformed packets. Assumes context words are one bus word each and
// payload items are ITEM_W bits; input packets end with tlast.
module pkt_hdr_parse
    import pkt_deframer_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int ITEM_W   = 32,
    parameter int MAX_META = 30
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DATA_W-1:0]        s_tdata,
    input  logic                     s_tvalid,
    input  logic                     s_tlast,
    output logic                     s_tready,
    output logic                     ctx_push,
    output logic [1:0]               ctx_kind,
    output logic                     ctx_last,
    input  logic                     ctx_room,
    output logic                     pay_push,
    output logic [DATA_W/ITEM_W-1:0] pay_keep,
    input  logic                     pay_room,
    output logic                     err_pulse
);
    localparam int BUS_B  = DATA_W / 8;
    localparam int ITEM_B = ITEM_W / 8;
    localparam int KEEP_W = DATA_W / ITEM_W;
    localparam int LEN_W  = 18;

    parse_st_t          st_q;
    logic [4:0]         meta_left_q;
    logic               time_pend_q;
    logic [KEEP_W-1:0]  keep_last_q;
    logic               err_q;

    logic [2:0]         h_type;
    logic [4:0]         h_meta;
    logic [15:0]        h_len;
    logic               h_timed;
    logic [LEN_W-1:0]   ctx_bytes;
    logic [LEN_W-1:0]   pay_bytes;
    logic               h_bad;
    logic               acc;
    logic [KEEP_W-1:0]  keep_calc;

    // Header field decode and layout check
    always_comb begin
        h_type    = s_tdata[55:53];
        h_meta    = s_tdata[52:48];
        h_len     = s_tdata[31:16];
        h_timed   = (h_type == TYPE_TIMED);
        ctx_bytes = LEN_W'((32'd1 + 32'(h_timed) + 32'(h_meta)) * BUS_B);
        pay_bytes = LEN_W'(h_len) - ctx_bytes;
        h_bad     = (32'(h_meta) > MAX_META) ||
                    (LEN_W'(h_len) < ctx_bytes + LEN_W'(ITEM_B));
    end

    // Last-beat item mask from the payload byte count
    always_comb begin
        int rem_b;
        int n_items;
        rem_b   = int'(pay_bytes) % BUS_B;
        n_items = (rem_b == 0) ? KEEP_W : (rem_b + ITEM_B - 1) / ITEM_B;
        for (int i = 0; i < KEEP_W; i++) keep_calc[i] = (i < n_items);
    end

    // Input acceptance follows the buffer the current word is bound for
    always_comb begin
        case (st_q)
            ST_HDR, ST_CTX: s_tready = ctx_room;
            ST_PAY:         s_tready = pay_room;
            default:        s_tready = 1'b1;
        endcase
    end

    assign acc = s_tvalid && s_tready;

    // Steering, context labels and end markers for the current word
    always_comb begin
        ctx_push = acc && ((st_q == ST_HDR && !h_bad) || st_q == ST_CTX);
        pay_push = acc && (st_q == ST_PAY);
        if (st_q == ST_HDR) begin
            ctx_kind = KIND_HDR;
            ctx_last = !h_timed && (h_meta == 5'd0);
        end else begin
            ctx_kind = time_pend_q ? KIND_TIME : KIND_META;
            ctx_last = time_pend_q ? (meta_left_q == 5'd0) : (meta_left_q == 5'd1);
        end
        pay_keep = s_tlast ? keep_last_q : {KEEP_W{1'b1}};
    end

    // Parser phase, remaining context count and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_HDR;
            meta_left_q <= '0;
            time_pend_q <= 1'b0;
            keep_last_q <= '1;
            err_q       <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (acc) begin
                case (st_q)
                    ST_HDR: begin
                        if (h_bad) begin
                            err_q <= 1'b1;
                            st_q  <= s_tlast ? ST_HDR : ST_DROP;
                        end else begin
                            time_pend_q <= h_timed;
                            meta_left_q <= h_meta;
                            keep_last_q <= keep_calc;
                            st_q <= (h_timed || h_meta != 5'd0) ? ST_CTX : ST_PAY;
                        end
                    end
                    ST_CTX: begin
                        if (time_pend_q) begin
                            time_pend_q <= 1'b0;
                            if (meta_left_q == 5'd0) st_q <= ST_PAY;
                        end else begin
                            meta_left_q <= meta_left_q - 5'd1;
                            if (meta_left_q == 5'd1) st_q <= ST_PAY;
                        end
                    end
                    ST_PAY:  if (s_tlast) st_q <= ST_HDR;
                    default: if (s_tlast) st_q <= ST_HDR;
                endcase
            end
        end
    end

    assign err_pulse = err_q;

    // R8: nothing reaches either buffer while a bad packet is drained
    p_drop_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DROP) |-> (!ctx_push && !pay_push));

    // R7: the error flag only follows a header-phase acceptance
    p_err_after_hdr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> ($past(st_q) == ST_HDR && $past(acc)));

    // R3: metadata count never runs past the legal maximum in the context phase
    p_meta_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CTX) |-> (32'(meta_left_q) <= MAX_META));

endmodule

// File: rtl/pkt_deframer.sv
// Module: top of the packet deframer. Joins the header parser to one
// two-entry buffer per output stream. Assumes 32-bit items on a 64-bit bus
// by default; both are parameters.
module pkt_deframer
    import pkt_deframer_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int ITEM_W   = 32,
    parameter int MAX_META = 30
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DATA_W-1:0]        s_tdata,
    input  logic                     s_tvalid,
    input  logic                     s_tlast,
    output logic                     s_tready,
    output logic [DATA_W-1:0]        ctx_tdata,
    output logic [1:0]               ctx_tuser,
    output logic                     ctx_tlast,
    output logic                     ctx_tvalid,
    input  logic                     ctx_tready,
    output logic [DATA_W-1:0]        pay_tdata,
    output logic [DATA_W/ITEM_W-1:0] pay_tkeep,
    output logic                     pay_tlast,
    output logic                     pay_tvalid,
    input  logic                     pay_tready,
    output logic                     err_pulse
);
    localparam int KEEP_W = DATA_W / ITEM_W;
    localparam int CTX_W  = DATA_W + 3;
    localparam int PAY_W  = DATA_W + KEEP_W + 1;

    logic              ctx_push, ctx_last, ctx_room;
    logic [1:0]        ctx_kind;
    logic              pay_push, pay_room;
    logic [KEEP_W-1:0] pay_keep;
    logic [CTX_W-1:0]  ctx_word;
    logic [PAY_W-1:0]  pay_word;

    pkt_hdr_parse #(
        .DATA_W  (DATA_W),
        .ITEM_W  (ITEM_W),
        .MAX_META(MAX_META)
    ) u_parse (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_tdata  (s_tdata),
        .s_tvalid (s_tvalid),
        .s_tlast  (s_tlast),
        .s_tready (s_tready),
        .ctx_push (ctx_push),
        .ctx_kind (ctx_kind),
        .ctx_last (ctx_last),
        .ctx_room (ctx_room),
        .pay_push (pay_push),
        .pay_keep (pay_keep),
        .pay_room (pay_room),
        .err_pulse(err_pulse)
    );

    pkt_skid #(.W(CTX_W)) u_ctx_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  ({ctx_kind, ctx_last, s_tdata}),
        .in_valid (ctx_push),
        .in_ready (ctx_room),
        .out_data (ctx_word),
        .out_valid(ctx_tvalid),
        .out_ready(ctx_tready)
    );

    pkt_skid #(.W(PAY_W)) u_pay_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  ({pay_keep, s_tlast, s_tdata}),
        .in_valid (pay_push),
        .in_ready (pay_room),
        .out_data (pay_word),
        .out_valid(pay_tvalid),
        .out_ready(pay_tready)
    );

    // Unpack buffered words onto the output ports
    always_comb begin
        {ctx_tuser, ctx_tlast, ctx_tdata} = ctx_word;
        {pay_tkeep, pay_tlast, pay_tdata} = pay_word;
    end

    // R10: outputs quiet right after reset
    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (!ctx_tvalid && !pay_tvalid && !err_pulse));

    // R2: context kind code 1 is never produced
    p_no_kind1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_tvalid |-> (ctx_tuser != 2'd1));

    // R6: only the final payload beat may clear items
    p_keep_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_tvalid && !pay_tlast) |-> (pay_tkeep == {KEEP_W{1'b1}}));

endmodule

// File: tb/pkt_deframer_tb.sv
// Bench: directed scenarios, each task sends packets and checks both outputs.
module pkt_deframer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tlast = 1'b0;
    logic        s_tready;
    logic [63:0] ctx_tdata;
    logic [1:0]  ctx_tuser;
    logic        ctx_tlast, ctx_tvalid;
    logic        ctx_tready = 1'b1;
    logic [63:0] pay_tdata;
    logic [1:0]  pay_tkeep;
    logic        pay_tlast, pay_tvalid;
    logic        pay_tready = 1'b1;
    logic        err_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int err_seen = 0;
    logic bp = 1'b0;
    int cyc = 0;
    logic [66:0] ctx_q[$];
    logic [66:0] pay_q[$];
    logic [66:0] ctx_exp[$];
    logic [66:0] pay_exp[$];

    pkt_deframer u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
        .ctx_tdata(ctx_tdata), .ctx_tuser(ctx_tuser), .ctx_tlast(ctx_tlast),
        .ctx_tvalid(ctx_tvalid), .ctx_tready(ctx_tready),
        .pay_tdata(pay_tdata), .pay_tkeep(pay_tkeep), .pay_tlast(pay_tlast),
        .pay_tvalid(pay_tvalid), .pay_tready(pay_tready),
        .err_pulse(err_pulse)
    );

    always #10 clk = ~clk;

    // Consumer ready pattern, changed well after the rising edge
    always @(posedge clk) begin
        cyc = cyc + 1;
        #3;
        ctx_tready = bp ? (cyc[0] ^ cyc[2]) : 1'b1;
        pay_tready = bp ? cyc[1] : 1'b1;
    end

    // Output monitor at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (ctx_tvalid && ctx_tready) ctx_q.push_back({ctx_tuser, ctx_tlast, ctx_tdata});
            if (pay_tvalid && pay_tready) pay_q.push_back({pay_tkeep, pay_tlast, pay_tdata});
            if (err_pulse) err_seen = err_seen + 1;
        end
    end

    // Watchdog
    initial begin
        #(20 * 150000);
        n_chk = n_chk + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog: act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic check(input logic ok, input string req, input logic [66:0] act, input logic [66:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_hdr(input logic [2:0] typ, input logic [4:0] nm, input logic [15:0] len, input logic [15:0] seq);
        return {6'd1, 2'b00, typ, nm, seq, len, 16'h0042};
    endfunction

    // Send one beat at the falling edge and hold until accepted
    task automatic put(input logic [63:0] d, input logic last);
        s_tdata  = d;
        s_tlast  = last;
        s_tvalid = 1'b1;
        while (!s_tready) @(negedge clk);
        @(negedge clk);
        s_tvalid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 60; i++) @(negedge clk);
    endtask

    // Build and send a well-formed packet, recording the expected beats
    task automatic gen_pkt(input logic [2:0] typ, input int nm, input int items, input logic [15:0] seq);
        int ctxw;
        int words;
        logic [15:0] len;
        logic [1:0] klast;
        ctxw  = 1 + ((typ == 3'd7) ? 1 : 0) + nm;
        words = (items + 1) / 2;
        len   = 16'(ctxw * 8 + items * 4);
        klast = (items % 2 == 0) ? 2'b11 : 2'b01;
        put(mk_hdr(typ, 5'(nm), len, seq), 1'b0);
        ctx_exp.push_back({2'd0, ctxw == 1, mk_hdr(typ, 5'(nm), len, seq)});
        if (typ == 3'd7) begin
            put(64'hA000_0000_0000_0000 | 64'(seq), 1'b0);
            ctx_exp.push_back({2'd2, nm == 0, 64'hA000_0000_0000_0000 | 64'(seq)});
        end
        for (int m = 0; m < nm; m++) begin
            put(64'hB000_0000_0000_0000 | 64'(m) | (64'(seq) << 16), 1'b0);
            ctx_exp.push_back({2'd3, m == nm - 1, 64'hB000_0000_0000_0000 | 64'(m) | (64'(seq) << 16)});
        end
        for (int p = 0; p < words; p++) begin
            logic lst;
            lst = (p == words - 1);
            put(64'hC000_0000_0000_0000 | 64'(p) | (64'(seq) << 24), lst);
            pay_exp.push_back({lst ? klast : 2'b11, lst, 64'hC000_0000_0000_0000 | 64'(p) | (64'(seq) << 24)});
        end
    endtask

    task automatic send_bad(input logic [63:0] hdr, input int extra);
        put(hdr, extra == 0);
        for (int i = 0; i < extra; i++) put(64'hDEAD_0000_0000_0000 | 64'(i), i == extra - 1);
    endtask

    // Compare monitored beats against the expected lists
    task automatic compare(input string req);
        check(ctx_q.size() == ctx_exp.size(), {req, " ctx count"}, 67'(ctx_q.size()), 67'(ctx_exp.size()));
        check(pay_q.size() == pay_exp.size(), {req, " pay count"}, 67'(pay_q.size()), 67'(pay_exp.size()));
        for (int i = 0; i < ctx_exp.size() && i < ctx_q.size(); i++)
            check(ctx_q[i] == ctx_exp[i], {req, " ctx beat"}, ctx_q[i], ctx_exp[i]);
        for (int i = 0; i < pay_exp.size() && i < pay_q.size(); i++)
            check(pay_q[i] == pay_exp[i], {req, " pay beat"}, pay_q[i], pay_exp[i]);
        ctx_q.delete(); pay_q.delete(); ctx_exp.delete(); pay_exp.delete();
    endtask

    task automatic t_reset();
        check(!ctx_tvalid && !pay_tvalid && !err_pulse, "R10 reset outputs",
              67'({ctx_tvalid, pay_tvalid, err_pulse}), 67'(0));
    endtask

    task automatic t_plain();
        // R1 R4 R5 R6: untimed, no metadata, full last beat
        gen_pkt(3'd6, 0, 4, 16'd1);
        drain();
        compare("R1 R4 R5 R6 plain");
    endtask

    task automatic t_timed_meta();
        // R2 R3 R6: timestamp plus two metadata words, half last beat
        gen_pkt(3'd7, 2, 3, 16'd2);
        drain();
        compare("R2 R3 R6 timed");
        // R3 R6: one metadata word, single half payload word
        gen_pkt(3'd6, 1, 1, 16'd3);
        drain();
        compare("R3 R6 single");
    endtask

    task automatic t_bad_meta();
        int e0;
        e0 = err_seen;
        send_bad(mk_hdr(3'd6, 5'd31, 16'd1000, 16'd9), 3);
        drain();
        check(err_seen - e0 == 1, "R7 err pulses", 67'(err_seen - e0), 67'(1));
        compare("R7 dropped");
    endtask

    task automatic t_bad_len();
        int e0;
        e0 = err_seen;
        // timed with 1 metadata word needs 24 + 4 bytes; give 24
        send_bad(mk_hdr(3'd7, 5'd1, 16'd24, 16'd10), 2);
        send_bad(mk_hdr(3'd6, 5'd0, 16'd8, 16'd11), 0);
        gen_pkt(3'd6, 0, 2, 16'd12);
        drain();
        check(err_seen - e0 == 2, "R8 err pulses", 67'(err_seen - e0), 67'(2));
        compare("R8 drop then good");
    endtask

    task automatic t_stall();
        int e0;
        e0 = err_seen;
        bp = 1'b1;
        // R9: stalls on both outputs, drop lands while payload is held
        gen_pkt(3'd7, 3, 9, 16'd20);
        send_bad(mk_hdr(3'd6, 5'd31, 16'd64, 16'd21), 1);
        gen_pkt(3'd6, 2, 6, 16'd22);
        gen_pkt(3'd7, 0, 1, 16'd23);
        drain();
        bp = 1'b0;
        drain();
        check(err_seen - e0 == 1, "R9 R7 err under stall", 67'(err_seen - e0), 67'(1));
        compare("R9 stall");
    endtask

    initial begin
        for (int i = 0; i < 4; i++) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_timed_meta();
        t_bad_meta();
        t_bad_len();
        t_stall();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule